// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous static memory that registers its address, control and write data on the clock edge and returns read data one edge later through an output register. A burst begins when either of two start strobes is sampled while the chip is selected. The advance input then steps through three more words of an aligned group of four. The order is linear or interleaved, chosen by a static mode input. Only the two lowest address bits take part in the burst. The upper bits stay as loaded.

Writes use the same issue path as reads. A global write stores the whole word. Otherwise a byte-write qualifier lets per-byte selects choose which byte lanes are stored. A sleep input blocks every access while it is high. An output enable gates the read data combinationally. Depth, byte count and byte width are parameters, and the default memory is 64 words of four bytes.

Top module: `burst_sram`

## Requirements
- R1: After reset, `rd_drive_o` is 0 and `rdata_o` is all zeros until a read reaches the output stage.
- R2: A read issued on clock edge E (start or advance) presents its word on `rdata_o` after edge E+1, with `rd_drive_o` high when `oe_i` is 1.
- R3: With `ilv_i`=0, each advance sets the low two address bits to (start + beat) mod 4, for beats 1, 2 and 3. For a start value of 1 this gives 1, 2, 3, 0. A fourth advance returns to the start word.
- R4: With `ilv_i`=1, the low two address bits of beat k are the start bits XOR k. For a start value of 2 this gives 2, 3, 0, 1.
- R5: Address bits above bit 1 never change during a burst, including when the low bits wrap from 3 to 0.
- R6: When `gwr_i`=1 the access writes all bytes of `wdata_i`, whatever `bwen_i` and `bsel_i` hold.
- R7: When `gwr_i`=0 and `bwen_i`=1, only the byte lanes whose `bsel_i` bit is 1 are written (bit b selects `wdata_i[8b+7:8b]`). If `bwen_i`=0, `bsel_i` is ignored and the access is a read.
- R8: Either `strb_a_i` or `strb_b_i` starts a burst at `addr_i`, and the two have the same effect.
- R9: A strobe sampled with `cs_i`=0 issues no access. The output is idle one cycle later, and the burst ends, so later advances issue nothing.
- R10: While `sleep_i`=1 no access is issued and any burst is cancelled. Strobes and advances in that cycle have no effect.
- R11: `rd_drive_o` is high only when a read is in the output stage and `oe_i`=1. `rdata_o` is zero whenever `rd_drive_o` is low. Writes never drive the output.
- R12: A cycle without a strobe and with `adv_i`=0 issues no access and leaves the burst position unchanged, so a later advance continues the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Low-power idle, blocks all access |
| cs_i | input | 1 | Chip select, sampled with a strobe |
| strb_a_i | input | 1 | Burst start strobe, first source |
| strb_b_i | input | 1 | Burst start strobe, second source |
| adv_i | input | 1 | Step to the next burst word |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | Start address |
| gwr_i | input | 1 | Global write, all bytes |
| bwen_i | input | 1 | Byte-write qualifier |
| bsel_i | input | NBYTES | Per-byte write selects |
| wdata_i | input | NBYTES*BYTE_W | Write data |
| oe_i | input | 1 | Output enable, combinational |
| rdata_o | output | NBYTES*BYTE_W | Read data, zero when not driven |
| rd_drive_o | output | 1 | Read data valid and enabled |

## Verification
The properties assume that `oe_i` and the write controls in a strobe cycle carry known levels, and that `rst_n` stays high across the two-cycle windows they check. The bench changes inputs only on falling edges and keeps reset released after the start. A behavioural model with a word array and an explicit pipeline slot is compared with both outputs after every edge. The stimulus fills every word first, so each read compares against a defined value.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // low two address bits of a burst beat, linear or interleaved
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              cs_i,
  input  logic              strb_a_i,
  input  logic              strb_b_i,
  input  logic              adv_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic              act_q, act_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              load, start, step;
  logic [1:0]        nxt_beat;

  always_comb begin
    load     = !sleep_i && (strb_a_i || strb_b_i);
    start    = load && cs_i;
    step     = !sleep_i && !load && act_q && adv_i;
    nxt_beat = cnt_q + 2'd1;

    act_d  = act_q;
    cnt_d  = cnt_q;
    base_d = base_q;
    if (sleep_i) begin
      act_d = 1'b0;
    end else if (load) begin
      act_d = cs_i;
    end
    if (start) begin
      cnt_d  = 2'd0;
      base_d = addr_i;
    end else if (step) begin
      cnt_d = nxt_beat;
    end

    acc_o = start || step;
    if (start) begin
      acc_addr_o = addr_i;
    end else begin
      acc_addr_o = {base_q[ADDR_W-1 -: HI_W], beat_lo(base_q[1:0], nxt_beat, ilv_i)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/req_stage.sv
module req_stage #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_i,
  input  logic [ADDR_W-1:0]        acc_addr_i,
  input  logic                     gwr_i,
  input  logic                     bwen_i,
  input  logic [NBYTES-1:0]        bsel_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic                     vld_o,
  output logic                     wr_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [NBYTES-1:0]        be_o,
  output logic [NBYTES*BYTE_W-1:0] wdata_o
);
  logic [NBYTES-1:0] be_d;

  always_comb begin
    if (gwr_i) begin
      be_d = '1;
    end else if (bwen_i) begin
      be_d = bsel_i;
    end else begin
      be_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= acc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o    <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
      wdata_o <= '0;
    end else if (acc_i) begin
      wr_o    <= |be_d;
      addr_o  <= acc_addr_i;
      be_o    <= be_d;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_core.sv
module sram_core #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NBYTES-1:0]        be_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic                     rd_vld_o,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  assign rd_en = vld_i && !wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_en;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (vld_i && be_i[b]) begin
        mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata_o[b*BYTE_W +: BYTE_W] <= '0;
      end else if (rd_en) begin
        rdata_o[b*BYTE_W +: BYTE_W] <= mem[addr_i];
      end
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep_i,
  input  logic                     cs_i,
  input  logic                     strb_a_i,
  input  logic                     strb_b_i,
  input  logic                     adv_i,
  input  logic                     ilv_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     gwr_i,
  input  logic                     bwen_i,
  input  logic [NBYTES-1:0]        bsel_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic                     oe_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o,
  output logic                     rd_drive_o
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [NBYTES-1:0] s1_be;
  logic [DATA_W-1:0] s1_wdata;
  logic              rd_vld;
  logic [DATA_W-1:0] rd_word;

  burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_i(cs_i),
    .strb_a_i(strb_a_i), .strb_b_i(strb_b_i), .adv_i(adv_i), .ilv_i(ilv_i),
    .addr_i(addr_i), .acc_o(acc), .acc_addr_o(acc_addr)
  );

  req_stage #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_req (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .acc_addr_i(acc_addr),
    .gwr_i(gwr_i), .bwen_i(bwen_i), .bsel_i(bsel_i), .wdata_i(wdata_i),
    .vld_o(s1_vld), .wr_o(s1_wr), .addr_o(s1_addr), .be_o(s1_be),
    .wdata_o(s1_wdata)
  );

  sram_core #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .vld_i(s1_vld), .wr_i(s1_wr), .addr_i(s1_addr),
    .be_i(s1_be), .wdata_i(s1_wdata), .rd_vld_o(rd_vld), .rdata_o(rd_word)
  );

  always_comb begin
    rd_drive_o = rd_vld && oe_i;
    rdata_o    = rd_drive_o ? rd_word : '0;
  end
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sleep_i,
  input logic                     cs_i,
  input logic                     strb_a_i,
  input logic                     strb_b_i,
  input logic                     gwr_i,
  input logic                     bwen_i,
  input logic                     oe_i,
  input logic [NBYTES*BYTE_W-1:0] rdata_o,
  input logic                     rd_drive_o
);
  // R2: a read start shows up in the output stage two samples later
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (strb_a_i || strb_b_i) && cs_i && !gwr_i && !bwen_i)
      |-> ##2 (rd_drive_o || !oe_i));

  // R6: a global write start never drives the data bus
  a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (strb_a_i || strb_b_i) && cs_i && gwr_i) |-> ##2 !rd_drive_o);

  // R9: a deselected strobe leaves the output idle
  a_r9_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (strb_a_i || strb_b_i) && !cs_i) |-> ##2 !rd_drive_o);

  // R10: sleep issues nothing
  a_r10_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> ##2 !rd_drive_o);

  // R11: the drive flag needs the output enable
  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive_o |-> oe_i);

  // R11: undriven data reads as zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive_o |-> (rdata_o == '0));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_i(cs_i),
  .strb_a_i(strb_a_i), .strb_b_i(strb_b_i), .gwr_i(gwr_i), .bwen_i(bwen_i),
  .oe_i(oe_i), .rdata_o(rdata_o), .rd_drive_o(rd_drive_o)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sleep_i, cs_i, strb_a_i, strb_b_i, adv_i, ilv_i;
  logic [AW-1:0] addr_i;
  logic          gwr_i, bwen_i, oe_i;
  logic [NB-1:0] bsel_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rd_drive_o;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // behavioural reference state
  logic [DW-1:0] mm [64];
  logic [AW-1:0] m_base;
  int            m_beat;
  logic          m_act;
  logic          m_s1v, m_s1w;
  logic [AW-1:0] m_s1a;
  logic [NB-1:0] m_s1be;
  logic [DW-1:0] m_s1wd;
  logic          m_ov;
  logic [DW-1:0] m_od;

  always #5 clk = ~clk;

  burst_sram u_burst_sram (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .cs_i(cs_i),
    .strb_a_i(strb_a_i), .strb_b_i(strb_b_i), .adv_i(adv_i), .ilv_i(ilv_i),
    .addr_i(addr_i), .gwr_i(gwr_i), .bwen_i(bwen_i), .bsel_i(bsel_i),
    .wdata_i(wdata_i), .oe_i(oe_i), .rdata_o(rdata_o), .rd_drive_o(rd_drive_o)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {2'b00, a, 8'hC3, 2'b01, a, 8'h5A};
  endfunction

  // one model step at a rising edge, using the inputs then present
  task automatic model_edge();
    logic [DW-1:0] w;
    logic          ld, st, sp;
    int            lo;
    if (m_s1v && m_s1w) begin
      w = mm[m_s1a];
      for (int b = 0; b < NB; b++)
        if (m_s1be[b]) w[b*8 +: 8] = m_s1wd[b*8 +: 8];
      mm[m_s1a] = w;
    end
    m_ov = m_s1v && !m_s1w;
    if (m_ov) m_od = mm[m_s1a];
    ld = !sleep_i && (strb_a_i || strb_b_i);
    st = ld && cs_i;
    sp = !sleep_i && !ld && m_act && adv_i;
    m_s1v = st || sp;
    if (st) begin
      m_s1a  = addr_i;
      m_base = addr_i;
      m_beat = 0;
    end else if (sp) begin
      m_beat = (m_beat + 1) % 4;
      if (ilv_i) lo = int'(m_base[1:0]) ^ m_beat;
      else       lo = (int'(m_base[1:0]) + m_beat) % 4;
      m_s1a = {m_base[AW-1:2], 2'(lo)};
    end
    if (m_s1v) begin
      m_s1be = gwr_i ? '1 : (bwen_i ? bsel_i : '0);
      m_s1w  = (m_s1be != 0);
      m_s1wd = wdata_i;
    end
    if (sleep_i) m_act = 1'b0;
    else if (ld) m_act = cs_i;
  endtask

  task automatic compare();
    logic          ed;
    logic [DW-1:0] ev;
    ed = m_ov && oe_i;
    ev = ed ? m_od : '0;
    total++;
    if (rd_drive_o !== ed || rdata_o !== ev) begin
      bad++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rd_drive_o, rdata_o, ed, ev);
    end
  endtask

  task automatic cyc(input logic sa, input logic sb, input logic cs,
                     input logic adv, input logic [AW-1:0] a,
                     input logic gw, input logic bwe, input logic [NB-1:0] bs,
                     input logic [DW-1:0] wd, input logic oe, input logic slp);
    strb_a_i = sa; strb_b_i = sb; cs_i = cs; adv_i = adv; addr_i = a;
    gwr_i = gw; bwen_i = bwe; bsel_i = bs; wdata_i = wd; oe_i = oe;
    sleep_i = slp;
    @(posedge clk);
    model_edge();
    #2;
    compare();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, 0, 0, '0, '0, 1, 0);
  endtask

  // read burst: start plus three advances plus two idle cycles to drain
  task automatic rd_burst(input logic [AW-1:0] a, input logic useb);
    cyc(!useb, useb, 1, 0, a, 0, 0, '0, '0, 1, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    idle(2);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_i = 0; cs_i = 0; strb_a_i = 0; strb_b_i = 0;
    adv_i = 0; ilv_i = 0; addr_i = '0; gwr_i = 0; bwen_i = 0; bsel_i = '0;
    wdata_i = '0; oe_i = 1;
    m_act = 0; m_beat = 0; m_base = '0; m_s1v = 0; m_s1w = 0; m_s1a = '0;
    m_s1be = '0; m_s1wd = '0; m_ov = 0; m_od = '0;
    for (int i = 0; i < 64; i++) mm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    tag = "R1";
    idle(2);

    // R6: global write fills memory, byte controls set to conflicting values
    tag = "R6";
    for (int i = 0; i < 64; i++)
      cyc(1, 0, 1, 0, 6'(i), 1, 1, 4'b0000, pat(6'(i)), 1, 0);
    idle(2);

    // R2 R3: linear burst from low bits 1 -> 1,2,3,0
    ilv_i = 0;
    tag = "R3";
    rd_burst(6'h09, 0);
    // R4: interleaved burst from low bits 2 -> 2,3,0,1
    ilv_i = 1;
    tag = "R4";
    rd_burst(6'h0E, 0);
    // R8: second strobe starts a burst
    tag = "R8";
    rd_burst(6'h21, 1);
    ilv_i = 0;
    // R5: start at low bits 3, wraps to 0 without touching upper bits
    tag = "R5";
    rd_burst(6'h17, 0);
    // R3: fourth advance returns to the start word
    tag = "R3";
    cyc(1, 0, 1, 0, 6'h2A, 0, 0, '0, '0, 1, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    idle(2);

    // R7: byte write of lanes 0 and 2 only
    tag = "R7";
    cyc(1, 0, 1, 0, 6'h05, 0, 1, 4'b0101, 32'hDEADBEEF, 1, 0);
    idle(1);
    cyc(1, 0, 1, 0, 6'h05, 0, 0, '0, '0, 1, 0);
    idle(2);
    // R7: selects without the qualifier are a read, memory unchanged
    cyc(1, 0, 1, 0, 6'h06, 0, 0, 4'b1111, 32'h12345678, 1, 0);
    idle(1);
    cyc(1, 0, 1, 0, 6'h06, 0, 0, '0, '0, 1, 0);
    idle(2);
    // R6: global write with advances writes a burst
    tag = "R6";
    cyc(1, 0, 1, 0, 6'h30, 1, 0, '0, 32'hA0A0A0A0, 1, 0);
    cyc(0, 0, 1, 1, '0, 1, 0, '0, 32'hA1A1A1A1, 1, 0);
    idle(1);
    rd_burst(6'h30, 0);

    // R9: deselected strobe mid-burst, then advances do nothing
    tag = "R9";
    cyc(1, 0, 1, 0, 6'h10, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 1, 0, 0, 6'h20, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    idle(2);

    // R10: sleep blocks a strobe and cancels a burst
    tag = "R10";
    cyc(1, 0, 1, 0, 6'h11, 0, 0, '0, '0, 1, 1);
    cyc(1, 0, 1, 0, 6'h11, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 1);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    idle(2);
    // R10: sleep write is not stored
    cyc(1, 0, 1, 0, 6'h12, 1, 0, '0, 32'hFFFF0000, 1, 1);
    idle(1);
    cyc(1, 0, 1, 0, 6'h12, 0, 0, '0, '0, 1, 0);
    idle(2);

    // R11: output enable low hides a read, then reveals the next
    tag = "R11";
    cyc(1, 0, 1, 0, 6'h33, 0, 0, '0, '0, 0, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 0, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, '0, '0, 0, 0);
    idle(2);

    // R12: gap with no advance, then the burst resumes in order
    tag = "R12";
    cyc(1, 0, 1, 0, 6'h3D, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 0, '0, 0, 0, '0, '0, 1, 0);
    cyc(0, 0, 1, 1, '0, 0, 0, '0, '0, 1, 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule